// File: doc/BRIEF.md
# Interlaced Proportional Glyph Renderer

This block turns a stream of raster positions into monochrome character pixels for an interlaced display. Each glyph keeps its own width, height and x/y placement inside its character cell. For every pixel the renderer looks up the glyph's packed metrics word, works out which glyph column and which glyph line fall under the beam, fetches the font word holding that pixel and emits one pixel per clock. The pixel comes with a flag that says whether it lies inside the glyph box.

In interlaced mode the current field picks the odd or the even glyph lines. A stroke that is one line thick therefore appears in only one of the two fields, and at a 50 Hz or 60 Hz field rate it flickers at half that rate. In non-interlaced mode only the even glyph lines are stored and shown, which halves the font store, and the field flag has no effect.

The caller presents one position per pixel strobe and receives results a fixed number of cycles later, with no stall and no gap between adjacent characters. The metrics memory and the font memory sit outside the block and are read through two synchronous read ports, each with one cycle of read latency.

Top module: `glyph_raster_renderer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pix_stb_o`, `pix_vld_o` and `pix_o` are 0.
- R2: Each 32-bit metrics word holds four 8-bit fields: glyph width in bits [7:0], height in [15:8], x offset in [23:16] and y offset in [31:24]. All four are fetched in one read at `met_addr_o`, which equals the character code sampled on the previous clock.
- R3: A strobe sampled on clock edge k produces `pix_stb_o` high after edge k+4. Back-to-back strobes give back-to-back outputs in the same order, and none are dropped or added.
- R4: The glyph column is `x - xoff`. A pixel whose column is negative or not below the width gives `pix_vld_o` = 0 and `pix_o` = 0.
- R5: In interlaced mode (`ilace_i` = 1) the glyph line is `2*line + field - yoff`. The pixel is inside only when that value lies in [0, height), and that glyph line is the font row that gets read.
- R6: In non-interlaced mode the glyph line is `2*line - yoff`, the font row is half of it rounded down, and `field_i` has no effect on any output.
- R7: The font word address is `code*SLOT_WORDS + row*ceil(width/WORD_W) + column/WORD_W`, taken modulo 2^FONT_AW.
- R8: Inside the box, `pix_o` is bit (column mod WORD_W) of the addressed font word, where bit 0 is the leftmost pixel of the word.
- R9: Widths and heights up to 255 are honoured: for a 255-wide glyph column 254 is inside and column 255 is outside.
- R10: When `pix_stb_o` is 0, `pix_vld_o` and `pix_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb_i | input | 1 | A raster position is presented this cycle |
| code_i | input | CODE_W | Character code of the cell under the beam |
| cell_x_i | input | 8 | Pixel column inside the character cell |
| cell_line_i | input | 8 | Line inside the cell, counted within the field |
| field_i | input | 1 | Field parity: 0 for even lines, 1 for odd lines |
| ilace_i | input | 1 | 1 selects interlaced mode, 0 selects non-interlaced mode |
| met_addr_o | output | CODE_W | Metrics memory read address |
| met_data_i | input | 32 | Metrics word, valid one cycle after the address |
| font_addr_o | output | FONT_AW | Font memory read address |
| font_data_i | input | WORD_W | Font word, valid one cycle after the address |
| pix_stb_o | output | 1 | Result strobe for the delayed position |
| pix_vld_o | output | 1 | Pixel lies inside the glyph box |
| pix_o | output | 1 | Ink bit, 0 for background |

## Verification
A wrong metrics field or a wrong field-to-line mapping shifts the glyph box. That shows as a `pix_vld_o` edge at the wrong column or line, on the very first strobe that crosses the boundary. A wrong row stride or word index fetches the wrong font word. With font contents that differ word by word, this corrupts `pix_o` within a few pixels of any glyph wider than one word. A lost or extra pipeline stage moves every `pix_stb_o` by one cycle and is caught on the first result after reset. The sweep covers every glyph of a small font and every column, line, field and mode near the glyph boxes, plus the 255-pixel limits.

// File: rtl/gr_pkg.sv
package gr_pkg;

    // Packed per-glyph metrics as held in one metrics memory word
    typedef struct packed {
        logic [7:0] yoff;
        logic [7:0] xoff;
        logic [7:0] height;
        logic [7:0] width;
    } glyph_met_t;

    // Raster position carried down the pipeline
    typedef struct packed {
        logic       stb;
        logic       ilace;
        logic       field;
        logic [7:0] line;
        logic [7:0] x;
    } raster_pos_t;

    localparam raster_pos_t POS_IDLE = '0;

    // Glyph column, 10-bit two's complement (negative when left of the box)
    function automatic logic [9:0] glyph_col(input logic [7:0] x, input logic [7:0] xoff);
        return {2'b00, x} - {2'b00, xoff};
    endfunction

    // Glyph line relative to the glyph top, in frame lines
    function automatic logic [9:0] glyph_line(input logic [7:0] line, input logic field,
                                              input logic ilace, input logic [7:0] yoff);
        logic [9:0] frame;
        frame = ilace ? {1'b0, line, field} : {1'b0, line, 1'b0};
        return frame - {2'b00, yoff};
    endfunction

endpackage

// File: rtl/gr_front.sv
module gr_front
    import gr_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  raster_pos_t       pos_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] met_addr_o,
    output raster_pos_t       pos_o,
    output logic [CODE_W-1:0] code_o
);

    raster_pos_t       s1_pos;
    logic [CODE_W-1:0] s1_code;
    logic              warm;

    // Stage 1: capture the position, start the metrics read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_pos  <= POS_IDLE;
            s1_code <= '0;
        end else begin
            s1_pos  <= pos_i;
            s1_code <= code_i;
        end
    end

    // Stage 2: position aligned with the returning metrics word
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_o  <= POS_IDLE;
            code_o <= '0;
        end else begin
            pos_o  <= s1_pos;
            code_o <= s1_code;
        end
    end

    assign met_addr_o = s1_code;

    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    AST_MET_ADDR_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst)
        warm |-> (met_addr_o == $past(code_i))); // R2

endmodule

// File: rtl/gr_geom.sv
module gr_geom
    import gr_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int WORD_W     = 32,
    parameter int SLOT_WORDS = 256,
    parameter int FONT_AW    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  raster_pos_t        pos_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [31:0]        met_data_i,
    output logic [FONT_AW-1:0] font_addr_o,
    output logic               stb_o,
    output logic               inbox_o,
    output logic [$clog2(WORD_W)-1:0] bitsel_o
);

    localparam int LOG_W = $clog2(WORD_W);

    glyph_met_t  met;
    logic [9:0]  col;
    logic [9:0]  gline;
    logic        in_x;
    logic        in_y;
    logic [8:0]  row;
    logic [31:0] wpr;
    logic [31:0] addr_full;

    always_comb begin
        met   = glyph_met_t'(met_data_i);
        col   = glyph_col(pos_i.x, met.xoff);
        gline = glyph_line(pos_i.line, pos_i.field, pos_i.ilace, met.yoff);
        in_x  = !col[9]   && (col[8:0]   < {1'b0, met.width});
        in_y  = !gline[9] && (gline[8:0] < {1'b0, met.height});
        // interlaced store keeps every line; the other store keeps even lines only
        row   = pos_i.ilace ? gline[8:0] : {1'b0, gline[8:1]};
        wpr   = (32'(met.width) + 32'(WORD_W - 1)) >> LOG_W;
        addr_full = 32'(code_i) * 32'(SLOT_WORDS)
                  + 32'(row) * wpr
                  + 32'(col[8:0] >> LOG_W);
    end

    // Stage 3: registered font address and pixel selection
    always_ff @(posedge clk) begin
        if (rst) begin
            font_addr_o <= '0;
            stb_o       <= 1'b0;
            inbox_o     <= 1'b0;
            bitsel_o    <= '0;
        end else begin
            font_addr_o <= addr_full[FONT_AW-1:0];
            stb_o       <= pos_i.stb;
            inbox_o     <= pos_i.stb && in_x && in_y;
            bitsel_o    <= col[LOG_W-1:0];
        end
    end

endmodule

// File: rtl/gr_serial.sv
module gr_serial #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic              inbox_i,
    input  logic [$clog2(WORD_W)-1:0] bitsel_i,
    input  logic [WORD_W-1:0] font_data_i,
    output logic              pix_stb_o,
    output logic              pix_vld_o,
    output logic              pix_o
);

    localparam int LOG_W = $clog2(WORD_W);

    logic             s4_stb;
    logic             s4_inbox;
    logic [LOG_W-1:0] s4_bitsel;

    // Stage 4: wait for the font word
    always_ff @(posedge clk) begin
        if (rst) begin
            s4_stb    <= 1'b0;
            s4_inbox  <= 1'b0;
            s4_bitsel <= '0;
        end else begin
            s4_stb    <= stb_i;
            s4_inbox  <= inbox_i;
            s4_bitsel <= bitsel_i;
        end
    end

    // Output register: pick the pixel out of the word
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_stb_o <= 1'b0;
            pix_vld_o <= 1'b0;
            pix_o     <= 1'b0;
        end else begin
            pix_stb_o <= s4_stb;
            pix_vld_o <= s4_inbox;
            pix_o     <= s4_inbox & font_data_i[s4_bitsel];
        end
    end

    AST_INK_INSIDE_BOX: assert property (@(posedge clk) disable iff (rst)
        pix_o |-> pix_vld_o); // R4
    AST_VLD_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        !pix_stb_o |-> (!pix_vld_o && !pix_o)); // R10

endmodule

// File: rtl/glyph_raster_renderer.sv
module glyph_raster_renderer
    import gr_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int WORD_W     = 32,
    parameter int SLOT_WORDS = 256,
    parameter int FONT_AW    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_stb_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [7:0]         cell_x_i,
    input  logic [7:0]         cell_line_i,
    input  logic               field_i,
    input  logic               ilace_i,
    output logic [CODE_W-1:0]  met_addr_o,
    input  logic [31:0]        met_data_i,
    output logic [FONT_AW-1:0] font_addr_o,
    input  logic [WORD_W-1:0]  font_data_i,
    output logic               pix_stb_o,
    output logic               pix_vld_o,
    output logic               pix_o
);

    localparam int LOG_W = $clog2(WORD_W);

    raster_pos_t       pos_in;
    raster_pos_t       s2_pos;
    logic [CODE_W-1:0] s2_code;
    logic              s3_stb;
    logic              s3_inbox;
    logic [LOG_W-1:0]  s3_bitsel;
    logic [2:0]        warm;

    always_comb begin
        pos_in.stb   = pix_stb_i;
        pos_in.ilace = ilace_i;
        pos_in.field = field_i;
        pos_in.line  = cell_line_i;
        pos_in.x     = cell_x_i;
    end

    gr_front #(.CODE_W(CODE_W)) u_front (
        .clk        (clk),
        .rst        (rst),
        .pos_i      (pos_in),
        .code_i     (code_i),
        .met_addr_o (met_addr_o),
        .pos_o      (s2_pos),
        .code_o     (s2_code)
    );

    gr_geom #(
        .CODE_W     (CODE_W),
        .WORD_W     (WORD_W),
        .SLOT_WORDS (SLOT_WORDS),
        .FONT_AW    (FONT_AW)
    ) u_geom (
        .clk         (clk),
        .rst         (rst),
        .pos_i       (s2_pos),
        .code_i      (s2_code),
        .met_data_i  (met_data_i),
        .font_addr_o (font_addr_o),
        .stb_o       (s3_stb),
        .inbox_o     (s3_inbox),
        .bitsel_o    (s3_bitsel)
    );

    gr_serial #(.WORD_W(WORD_W)) u_serial (
        .clk         (clk),
        .rst         (rst),
        .stb_i       (s3_stb),
        .inbox_i     (s3_inbox),
        .bitsel_i    (s3_bitsel),
        .font_data_i (font_data_i),
        .pix_stb_o   (pix_stb_o),
        .pix_vld_o   (pix_vld_o),
        .pix_o       (pix_o)
    );

    // Edges since reset release, saturating, for the latency check window
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 3'd7) warm <= warm + 3'd1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm >= 3'd5) |-> (pix_stb_o == $past(pix_stb_i, 5))); // R3
    AST_BOX_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        s3_inbox |-> s3_stb); // R10

endmodule

// File: tb/tb_glyph_raster_renderer.sv
module tb_glyph_raster_renderer;

    localparam int CODE_W = 3;
    localparam int WORD_W = 8;
    localparam int SLOT   = 64;
    localparam int AW     = 9;
    localparam int DEPTH  = 16384;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_stb_i = 1'b0;
    logic [CODE_W-1:0] code_i = '0;
    logic [7:0]        cell_x_i = '0;
    logic [7:0]        cell_line_i = '0;
    logic              field_i = 1'b0;
    logic              ilace_i = 1'b0;
    logic [CODE_W-1:0] met_addr_o;
    logic [31:0]       met_data_i = '0;
    logic [AW-1:0]     font_addr_o;
    logic [WORD_W-1:0] font_data_i = '0;
    logic              pix_stb_o;
    logic              pix_vld_o;
    logic              pix_o;

    glyph_raster_renderer #(
        .CODE_W(CODE_W), .WORD_W(WORD_W), .SLOT_WORDS(SLOT), .FONT_AW(AW)
    ) dut (
        .clk(clk), .rst(rst), .pix_stb_i(pix_stb_i), .code_i(code_i),
        .cell_x_i(cell_x_i), .cell_line_i(cell_line_i), .field_i(field_i),
        .ilace_i(ilace_i), .met_addr_o(met_addr_o), .met_data_i(met_data_i),
        .font_addr_o(font_addr_o), .font_data_i(font_data_i),
        .pix_stb_o(pix_stb_o), .pix_vld_o(pix_vld_o), .pix_o(pix_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    int wr    = 0;
    int rd    = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    int    exp_vld [DEPTH];
    int    exp_pix [DEPTH];
    int    exp_cyc [DEPTH];
    string exp_tag [DEPTH];

    // R2: width [7:0], height [15:8], xoff [23:16], yoff [31:24]
    function automatic logic [31:0] met_word(input int c);
        int w, h, xo, yo;
        if (c == 6) begin w = 0; h = 5; xo = 1; yo = 0; end
        else if (c == 7) begin w = 255; h = 255; xo = 0; yo = 0; end
        else begin
            w = 1 + (c * 5) % 16; h = 1 + (c * 7) % 20; xo = c % 4; yo = c % 3;
        end
        return {yo[7:0], xo[7:0], h[7:0], w[7:0]};
    endfunction

    function automatic logic [7:0] font_word(input int a);
        int v;
        v = (a * 37 + 11) ^ (a >> 3);
        return v[7:0];
    endfunction

    always @(posedge clk) begin
        cyc         <= cyc + 1;
        met_data_i  <= met_word(int'(met_addr_o));
        font_data_i <= font_word(int'(font_addr_o));
    end

    task automatic drive(input int c, input int x, input int ln, input int f, input int il);
        logic [31:0] m;
        int w, h, xo, yo, gx, g, row, wpr, addr, inb, bitv, idx;
        string tag;
        m  = met_word(c);
        w  = int'(m[7:0]);  h  = int'(m[15:8]);
        xo = int'(m[23:16]); yo = int'(m[31:24]);
        gx = x - xo;
        g  = (il != 0) ? (2 * ln + f - yo) : (2 * ln - yo);
        inb = (gx >= 0 && gx < w && g >= 0 && g < h) ? 1 : 0;
        row = (il != 0) ? g : (g >>> 1);
        wpr = (w + WORD_W - 1) / WORD_W;
        addr = (c * SLOT + row * wpr + gx / WORD_W) % (1 << AW);
        if (addr < 0) addr = addr + (1 << AW);
        bitv = 0;
        if (inb != 0) begin
            logic [7:0] fw;
            fw = font_word(addr);
            bitv = int'(fw[gx % WORD_W]);
        end
        if (c == 7) tag = "R9";
        else if (!(gx >= 0 && gx < w)) tag = "R4";
        else if (inb == 0) tag = (il != 0) ? "R5" : "R6";
        else tag = (il != 0) ? "R5 R7 R8" : "R6 R7 R8";
        @(negedge clk);
        pix_stb_i   = 1'b1;
        code_i      = c[CODE_W-1:0];
        cell_x_i    = x[7:0];
        cell_line_i = ln[7:0];
        field_i     = f[0];
        ilace_i     = il[0];
        idx = wr % DEPTH;
        exp_vld[idx] = inb;
        exp_pix[idx] = bitv;
        exp_cyc[idx] = cyc;
        exp_tag[idx] = tag;
        wr = wr + 1;
    endtask

    task automatic idle();
        @(negedge clk);
        pix_stb_i = 1'b0;
    endtask

    // Output monitor: compare in order, check latency of 5 counted edges
    always @(negedge clk) begin
        if (mon_en) begin
            if (pix_stb_o) begin
                total = total + 1;
                if (rd >= wr) begin
                    fails = fails + 1;
                    $display("FAIL R3: output strobe with nothing pending, actual 1 expected 0");
                end else begin
                    int idx;
                    idx = rd % DEPTH;
                    if (int'(pix_vld_o) != exp_vld[idx] || int'(pix_o) != exp_pix[idx]) begin
                        fails = fails + 1;
                        $display("FAIL %s: entry %0d vld/pix actual %0d/%0d expected %0d/%0d",
                                 exp_tag[idx], rd, pix_vld_o, pix_o, exp_vld[idx], exp_pix[idx]);
                    end else if (cyc - exp_cyc[idx] != 5) begin
                        fails = fails + 1;
                        $display("FAIL R3: entry %0d latency actual %0d expected 5",
                                 rd, cyc - exp_cyc[idx]);
                    end
                    rd = rd + 1;
                end
            end else begin
                total = total + 1;
                if (pix_vld_o || pix_o) begin
                    fails = fails + 1;
                    $display("FAIL R10: idle vld/pix actual %0d/%0d expected 0/0", pix_vld_o, pix_o);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails = fails + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1: outputs held low during reset
        total = total + 1;
        if (pix_stb_o || pix_vld_o || pix_o) begin
            fails = fails + 1;
            $display("FAIL R1: in reset stb/vld/pix actual %0d%0d%0d expected 000",
                     pix_stb_o, pix_vld_o, pix_o);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total = total + 1;
        if (pix_stb_o || pix_vld_o || pix_o) begin
            fails = fails + 1;
            $display("FAIL R1: after reset stb/vld/pix actual %0d%0d%0d expected 000",
                     pix_stb_o, pix_vld_o, pix_o);
        end
        mon_en = 1'b1;

        // Sweep every glyph over columns, lines, both fields and both modes
        n = 0;
        for (int il = 0; il < 2; il++)
            for (int c = 0; c < 8; c++)
                for (int ln = 0; ln < 13; ln++)
                    for (int f = 0; f < 2; f++)
                        for (int x = 0; x < 20; x++) begin
                            drive(c, x, ln, f, il);
                            n = n + 1;
                            if (n % 7 == 3) idle();
                        end

        // R9: limits of a 255 by 255 glyph
        for (int il = 0; il < 2; il++)
            for (int f = 0; f < 2; f++)
                for (int ln = 125; ln < 129; ln++)
                    for (int x = 250; x < 256; x++)
                        drive(7, x, ln, f, il);
        for (int x = 0; x < 256; x += 17) drive(7, x, 200, 1, 1);

        repeat (12) idle();
        // R3: every strobe produced exactly one result
        total = total + 1;
        if (rd != wr) begin
            fails = fails + 1;
            $display("FAIL R3: results actual %0d expected %0d", rd, wr);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule